// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block holds the host-visible registers of a single descriptor-driven DMA channel. A host reaches it over a simple 32-bit register bus with word addresses and byte enables. The control register works as a masked write: the upper half of the written word says which status flags to touch, and the lower half gives their new values. From these writes the block keeps the channel's run, pause, wake and flush flags. It derives the ACTIVE flag from them, sends a one-cycle kick to the descriptor sequencer when the channel is left active, and raises a one-cycle flush request towards the attached device.

The block also stores the aligned command pointer, which the host can change only while the channel is inactive. It holds three condition-select registers, for interrupt, branch and wait, each made of a 4-bit mask and a 4-bit match value. The descriptor sequencer reports its own events through dedicated strobes: command fetch, stop, fatal error, branch taken, pointer advance and flush completion. The device's 4-bit status is mirrored into the low bits of the status word.

Top module: `dma_chan_csr`

## Requirements
- R1: After synchronous reset every register reads zero: status word, command pointer and the select registers; kick and flush_req are low.
- R2: A control write (word offset 0) with mask bit 15 set and value bit 15 set sets RUN (status bit 15). With mask bit 15 set and value bit 15 clear it clears both RUN and DEAD (status bit 11).
- R3: A control write with mask bit 12 and value bit 12 set sets WAKE (status bit 12) only when RUN is set after that same write has been applied; otherwise WAKE stays clear and ACTIVE is not raised.
- R4: A control write with mask bit 14 set copies value bit 14 into PAUSE (status bit 14), whether that value is 0 or 1.
- R5: A control write with mask bit 13 and value bit 13 set sets FLUSH (status bit 13) and pulses flush_req for one cycle. FLUSH stays set until flush_done is seen.
- R6: After a control write, if PAUSE is set or RUN is clear, ACTIVE (status bit 10) is cleared and flush_req pulses. Otherwise ACTIVE is set when the write masked RUN or PAUSE or set WAKE. A write to none of these flags leaves ACTIVE unchanged.
- R7: A host write to the command pointer (word offset 3) is ignored while ACTIVE is set. Accepted values, from the host or from seq_ptr_we, have their low 4 bits forced to zero.
- R8: A read returns data one cycle later with bus_rvalid. Offsets 0 and 1 both return the status word {16'b0, flags[15:8], 4'b0, device status[3:0]}. Offsets 2 and 7 to 15 read zero. Host writes to offset 1 have no effect.
- R9: Offsets 4, 5 and 6 hold the interrupt, branch and wait selects. A write keeps bits 19:16 as the mask and bits 3:0 as the match value, and a read returns exactly those bits. Each select output is {mask, value}.
- R10: Only full-word accesses (bus_be = 4'hF) are accepted. A write with a partial byte enable changes nothing, and a read with one returns zero.
- R11: kick pulses for exactly the cycle after any control write that leaves ACTIVE set, and at no other time.
- R12: Sequencer strobes act on the status: seq_fetch clears WAKE, seq_stop clears ACTIVE, seq_kill sets DEAD and clears ACTIVE, seq_bt_set and seq_bt_clr set and clear BT (status bit 8). dev_status appears in status bits 3:0 one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| dev_status | input | 4 | Device condition bits |
| seq_fetch | input | 1 | Sequencer fetched a command (clears WAKE) |
| seq_stop | input | 1 | Sequencer executed a stop (clears ACTIVE) |
| seq_kill | input | 1 | Sequencer hit a fatal error (sets DEAD, clears ACTIVE) |
| seq_bt_set | input | 1 | Branch taken |
| seq_bt_clr | input | 1 | Sequential advance, clears branch-taken |
| seq_ptr_we | input | 1 | Sequencer updates the command pointer |
| seq_ptr | input | PTR_W | New command pointer from the sequencer |
| flush_done | input | 1 | Device finished a flush (clears FLUSH) |
| chan_status | output | 32 | Current status word |
| cmd_ptr | output | PTR_W | Aligned command pointer |
| intr_sel | output | 2*SEL_W | Interrupt select {mask, value} |
| branch_sel | output | 2*SEL_W | Branch select {mask, value} |
| wait_sel | output | 2*SEL_W | Wait select {mask, value} |
| kick | output | 1 | One-cycle activation kick to the sequencer |
| flush_req | output | 1 | One-cycle flush request to the device |

## Verification
The bench builds the block with its default parameters: 4-bit word addresses, a 32-bit pointer aligned to 16 bytes, and three select registers of 4-bit fields. With a 4-bit address the whole register window is reachable, including the unused offsets that must read zero. The 32-bit pointer shows that the alignment clears only the low nibble. The tests walk the channel through run, pause, resume, wake, flush, stop and error recovery. They set the status to known values and then try what should be ignored: pointer writes while active, writes to the status offset, partial byte enables, and a wake while stopped.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

  // Channel flags, mapped onto status word bits 15..8 (MSB first).
  typedef struct packed {
    logic run;     // 15
    logic pause;   // 14
    logic flush;   // 13
    logic wake;    // 12
    logic dead;    // 11
    logic active;  // 10
    logic rsv;     // 9
    logic bt;      // 8
  } flags_t;

  localparam int FLAG_LSB = 8;
  localparam int DEV_W    = 4;

  // Register word offsets
  localparam int OFS_CTRL   = 0;
  localparam int OFS_STAT   = 1;
  localparam int OFS_PTR    = 3;
  localparam int OFS_SEL0   = 4;

endpackage

// File: rtl/dmacsr_flag_next.sv
module dmacsr_flag_next
  import dmacsr_pkg::*;
(
  input  flags_t cur,
  input  logic   ev_fetch,
  input  logic   ev_stop,
  input  logic   ev_kill,
  input  logic   ev_bt_set,
  input  logic   ev_bt_clr,
  input  logic   ev_flush_done,
  input  logic   ctl_we,
  input  flags_t ctl_mask,
  input  flags_t ctl_val,
  output flags_t nxt,
  output logic   want_flush,
  output logic   want_kick
);

  always_comb begin
    flags_t f;
    f = cur;
    // sequencer events first, then a host control write on top
    if (ev_fetch)      f.wake   = 1'b0;
    if (ev_stop)       f.active = 1'b0;
    if (ev_kill) begin
      f.dead   = 1'b1;
      f.active = 1'b0;
    end
    if (ev_bt_set)     f.bt     = 1'b1;
    if (ev_bt_clr)     f.bt     = 1'b0;
    if (ev_flush_done) f.flush  = 1'b0;

    want_flush = 1'b0;
    want_kick  = 1'b0;
    if (ctl_we) begin
      if (ctl_mask.run) begin
        if (ctl_val.run) f.run = 1'b1;
        else begin
          f.run  = 1'b0;
          f.dead = 1'b0;
        end
      end
      if (ctl_mask.wake && ctl_val.wake && f.run) f.wake = 1'b1;
      if (ctl_mask.pause) f.pause = ctl_val.pause;
      if (ctl_mask.flush && ctl_val.flush) begin
        f.flush    = 1'b1;
        want_flush = 1'b1;
      end
      if (f.pause || !f.run) begin
        f.active   = 1'b0;
        want_flush = 1'b1;
      end else if (ctl_mask.run || ctl_mask.pause ||
                   (ctl_mask.wake && ctl_val.wake)) begin
        f.active = 1'b1;
      end
      want_kick = f.active;
    end
    f.rsv = 1'b0;
    nxt   = f;
  end

endmodule

// File: rtl/dmacsr_cmdptr.sv
module dmacsr_cmdptr #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [PTR_W-1:0] host_val,
  input  logic             locked,
  input  logic             seq_we,
  input  logic [PTR_W-1:0] seq_val,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] ALIGN_MASK = ~((PTR_W'(1) << ALIGN_BITS) - PTR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (seq_we) begin
      ptr <= seq_val & ALIGN_MASK;
    end else if (host_we && !locked) begin
      ptr <= host_val & ALIGN_MASK;
    end
  end

endmodule

// File: rtl/dmacsr_selbank.sv
module dmacsr_selbank #(
  parameter int NSEL  = 3,
  parameter int SEL_W = 4,
  parameter int MASK_LSB = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSEL-1:0]         we,
  input  logic [31:0]             wdata,
  output logic [NSEL*2*SEL_W-1:0] sel_flat
);

  generate
    for (genvar i = 0; i < NSEL; i++) begin : g_sel
      logic [SEL_W-1:0] msk_q;
      logic [SEL_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          msk_q <= '0;
          val_q <= '0;
        end else if (we[i]) begin
          msk_q <= wdata[MASK_LSB +: SEL_W];
          val_q <= wdata[0 +: SEL_W];
        end
      end
      assign sel_flat[i*2*SEL_W +: 2*SEL_W] = {msk_q, val_q};
    end
  endgenerate

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dmacsr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 4,
  parameter int SEL_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [3:0]        dev_status,
  input  logic              seq_fetch,
  input  logic              seq_stop,
  input  logic              seq_kill,
  input  logic              seq_bt_set,
  input  logic              seq_bt_clr,
  input  logic              seq_ptr_we,
  input  logic [PTR_W-1:0]  seq_ptr,
  input  logic              flush_done,
  output logic [31:0]       chan_status,
  output logic [PTR_W-1:0]  cmd_ptr,
  output logic [2*SEL_W-1:0] intr_sel,
  output logic [2*SEL_W-1:0] branch_sel,
  output logic [2*SEL_W-1:0] wait_sel,
  output logic              kick,
  output logic              flush_req
);

  localparam int NSEL     = 3;
  localparam int MASK_LSB = 16;
  localparam int PW       = (PTR_W < 32) ? PTR_W : 32;

  flags_t           flags_q, flags_d;
  logic [DEV_W-1:0] dev_q;
  logic             full_word, wr_ok, rd_ok;
  logic             ctl_we, ptr_we;
  logic [NSEL-1:0]  sel_we;
  logic             want_flush, want_kick;
  logic [NSEL*2*SEL_W-1:0] sel_flat;
  logic [31:0]      status_word, rd_mux;

  assign full_word = (bus_be == 4'hF);
  assign wr_ok     = bus_wr && full_word;
  assign rd_ok     = bus_rd && full_word;
  assign ctl_we    = wr_ok && (int'(bus_addr) == OFS_CTRL);
  assign ptr_we    = wr_ok && (int'(bus_addr) == OFS_PTR);

  generate
    for (genvar i = 0; i < NSEL; i++) begin : g_selwe
      assign sel_we[i] = wr_ok && (int'(bus_addr) == OFS_SEL0 + i);
    end
  endgenerate

  dmacsr_flag_next u_next (
    .cur           (flags_q),
    .ev_fetch      (seq_fetch),
    .ev_stop       (seq_stop),
    .ev_kill       (seq_kill),
    .ev_bt_set     (seq_bt_set),
    .ev_bt_clr     (seq_bt_clr),
    .ev_flush_done (flush_done),
    .ctl_we        (ctl_we),
    .ctl_mask      (flags_t'(bus_wdata[31:24])),
    .ctl_val       (flags_t'(bus_wdata[15:8])),
    .nxt           (flags_d),
    .want_flush    (want_flush),
    .want_kick     (want_kick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      dev_q     <= '0;
      kick      <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      dev_q     <= dev_status;
      kick      <= want_kick;
      flush_req <= want_flush;
    end
  end

  dmacsr_cmdptr #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .host_we  (ptr_we),
    .host_val (bus_wdata[PTR_W-1:0]),
    .locked   (flags_q.active),
    .seq_we   (seq_ptr_we),
    .seq_val  (seq_ptr),
    .ptr      (cmd_ptr)
  );

  dmacsr_selbank #(.NSEL(NSEL), .SEL_W(SEL_W), .MASK_LSB(MASK_LSB)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .we       (sel_we),
    .wdata    (bus_wdata),
    .sel_flat (sel_flat)
  );

  assign intr_sel   = sel_flat[0*2*SEL_W +: 2*SEL_W];
  assign branch_sel = sel_flat[1*2*SEL_W +: 2*SEL_W];
  assign wait_sel   = sel_flat[2*2*SEL_W +: 2*SEL_W];

  assign status_word = {16'b0, flags_q, {(8-DEV_W){1'b0}}, dev_q};
  assign chan_status = status_word;

  always_comb begin
    rd_mux = '0;
    if (int'(bus_addr) == OFS_CTRL || int'(bus_addr) == OFS_STAT) begin
      rd_mux = status_word;
    end else if (int'(bus_addr) == OFS_PTR) begin
      rd_mux[PW-1:0] = cmd_ptr[PW-1:0];
    end else begin
      for (int i = 0; i < NSEL; i++) begin
        if (int'(bus_addr) == OFS_SEL0 + i) begin
          rd_mux[MASK_LSB +: SEL_W] = sel_flat[i*2*SEL_W + SEL_W +: SEL_W];
          rd_mux[0 +: SEL_W]        = sel_flat[i*2*SEL_W +: SEL_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= rd_ok ? rd_mux : 32'b0;
    end
  end

endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
  parameter int ADDR_W = 4,
  parameter int PTR_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              st_run,
  input logic              st_pause,
  input logic              st_dead,
  input logic              st_active,
  input logic              kick,
  input logic              flush_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              seq_ptr_we,
  input logic              seq_kill,
  input logic [PTR_W-1:0]  cmd_ptr
);

  // R1: reset clears the flags and the pointer
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!st_run && !st_active && cmd_ptr == '0));

  // R6: ACTIVE never coexists with PAUSE or a cleared RUN
  assert_active_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
    st_active |-> (st_run && !st_pause));

  // R6: stopping the channel comes with a flush request
  assert_stop_flushes_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(st_run) |-> flush_req);

  // R11: a kick is only sent while the channel is active
  assert_kick_active_R11: assert property (@(posedge clk) disable iff (rst)
    kick |-> st_active);

  // R7: host pointer write while active leaves the pointer alone
  assert_ptr_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) == 3 && bus_be == 4'hF && st_active && !seq_ptr_we)
      |=> $stable(cmd_ptr));

  // R12: DEAD rises only after a fatal-error strobe
  assert_dead_source_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(st_dead) |-> $past(seq_kill));

endmodule

bind dma_chan_csr dma_chan_csr_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st_run     (chan_status[15]),
  .st_pause   (chan_status[14]),
  .st_dead    (chan_status[11]),
  .st_active  (chan_status[10]),
  .kick       (kick),
  .flush_req  (flush_req),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .seq_ptr_we (seq_ptr_we),
  .seq_kill   (seq_kill),
  .cmd_ptr    (cmd_ptr)
);

// File: tb/tb_dma_chan_csr.sv
`timescale 1ns/1ps
module tb_dma_chan_csr;

  localparam int ADDR_W = 4;
  localparam int PTR_W  = 32;
  localparam int SEL_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0]        bus_be = 4'hF;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [3:0]        dev_status = '0;
  logic              seq_fetch = 0, seq_stop = 0, seq_kill = 0;
  logic              seq_bt_set = 0, seq_bt_clr = 0, seq_ptr_we = 0;
  logic [PTR_W-1:0]  seq_ptr = '0;
  logic              flush_done = 0;
  logic [31:0]       chan_status;
  logic [PTR_W-1:0]  cmd_ptr;
  logic [2*SEL_W-1:0] intr_sel, branch_sel, wait_sel;
  logic              kick, flush_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_chan_csr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .SEL_W(SEL_W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at negedge, held across one posedge; results visible at the next negedge
  task automatic host_wr(input int ofs, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1; bus_addr = ADDR_W'(ofs); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = 4'hF;
  endtask

  task automatic host_rd(input int ofs, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd = 1; bus_addr = ADDR_W'(ofs); bus_be = be;
    @(negedge clk);
    bus_rd = 0; bus_be = 4'hF;
    check("R8 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  // bits: {fetch, stop, kill, bt_set, bt_clr, flush_done}
  task automatic seq_pulse(input logic [5:0] v);
    @(negedge clk);
    {seq_fetch, seq_stop, seq_kill, seq_bt_set, seq_bt_clr, flush_done} = v;
    @(negedge clk);
    {seq_fetch, seq_stop, seq_kill, seq_bt_set, seq_bt_clr, flush_done} = '0;
  endtask

  task automatic t_reset;
    check("R1 status", chan_status, 32'h0);
    check("R1 cmd_ptr", cmd_ptr, 32'h0);
    check("R1 selects", {8'b0, intr_sel, branch_sel, wait_sel}, 32'h0);
    check("R1 pulses", {30'b0, kick, flush_req}, 32'h0);
  endtask

  task automatic t_ptr_idle;
    logic [31:0] r;
    host_wr(3, 32'h1234_567F);
    check("R7 aligned ptr", cmd_ptr, 32'h1234_5670);
    host_rd(3, r);
    check("R8 ptr readback", r, 32'h1234_5670);
  endtask

  task automatic t_run;
    host_wr(0, 32'h8000_8000);
    check("R2 run set", chan_status, 32'h0000_8400);
    check("R11 kick", {31'b0, kick}, 32'd1);
    check("R6 no flush", {31'b0, flush_req}, 32'd0);
    @(negedge clk);
    check("R11 kick one cycle", {31'b0, kick}, 32'd0);
  endtask

  task automatic t_ptr_active;
    host_wr(3, 32'hABCD_0000);
    check("R7 locked while active", cmd_ptr, 32'h1234_5670);
    @(negedge clk);
    seq_ptr_we = 1; seq_ptr = 32'h0000_2018;
    @(negedge clk);
    seq_ptr_we = 0;
    check("R7 sequencer ptr", cmd_ptr, 32'h0000_2010);
  endtask

  task automatic t_pause;
    host_wr(0, 32'h4000_4000);
    check("R4 pause set", chan_status, 32'h0000_C000);
    check("R6 pause flush", {30'b0, flush_req, kick}, 32'h2);
    host_wr(0, 32'h4000_0000);
    check("R4 pause clear", chan_status, 32'h0000_8400);
    check("R11 resume kick", {31'b0, kick}, 32'd1);
  endtask

  task automatic t_wake;
    seq_pulse(6'b010000);
    check("R12 stop clears active", chan_status, 32'h0000_8000);
    host_wr(0, 32'h1000_1000);
    check("R3 wake running", chan_status, 32'h0000_9400);
    check("R11 wake kick", {31'b0, kick}, 32'd1);
    seq_pulse(6'b100000);
    check("R12 fetch clears wake", chan_status, 32'h0000_8400);
  endtask

  task automatic t_flush;
    host_wr(0, 32'h2000_2000);
    check("R5 flush set", chan_status, 32'h0000_A400);
    check("R5 flush_req", {31'b0, flush_req}, 32'd1);
    @(negedge clk);
    check("R5 flush held", chan_status, 32'h0000_A400);
    seq_pulse(6'b000001);
    check("R5 flush done", chan_status, 32'h0000_8400);
  endtask

  task automatic t_readmap;
    logic [31:0] r;
    host_rd(0, r);
    check("R8 ctrl reads status", r, 32'h0000_8400);
    host_rd(1, r);
    check("R8 status read", r, 32'h0000_8400);
    host_wr(1, 32'h0000_FFFF);
    check("R8 status write ignored", chan_status, 32'h0000_8400);
    host_rd(2, r);
    check("R8 offset2 zero", r, 32'h0);
    host_rd(9, r);
    check("R8 offset9 zero", r, 32'h0);
    host_rd(15, r);
    check("R8 offset15 zero", r, 32'h0);
  endtask

  task automatic t_sel;
    logic [31:0] r;
    host_wr(4, 32'hFFFF_FFFF);
    host_rd(4, r);
    check("R9 intr readback", r, 32'h000F_000F);
    check("R9 intr out", {24'b0, intr_sel}, 32'hFF);
    host_wr(5, 32'h0003_0005);
    host_rd(5, r);
    check("R9 branch readback", r, 32'h0003_0005);
    check("R9 branch out", {24'b0, branch_sel}, 32'h35);
    check("R9 wait untouched", {24'b0, wait_sel}, 32'h00);
  endtask

  task automatic t_partial;
    logic [31:0] r;
    host_wr(0, 32'h8000_0000, 4'h3);
    check("R10 partial write ignored", chan_status, 32'h0000_8400);
    host_wr(6, 32'h000F_000F, 4'h1);
    check("R10 partial select ignored", {24'b0, wait_sel}, 32'h00);
    host_rd(0, r, 4'h3);
    check("R10 partial read zero", r, 32'h0);
  endtask

  task automatic t_stop_run;
    host_wr(0, 32'h8000_0000);
    check("R2 run clear", chan_status, 32'h0);
    check("R6 stop flush", {30'b0, flush_req, kick}, 32'h2);
    host_wr(0, 32'h1000_1000);
    check("R3 wake while stopped", chan_status, 32'h0);
    check("R11 no kick", {31'b0, kick}, 32'd0);
  endtask

  task automatic t_dead;
    host_wr(0, 32'h8000_8000);
    seq_pulse(6'b001000);
    check("R12 kill", chan_status, 32'h0000_8800);
    host_wr(0, 32'h8000_0000);
    check("R2 dead cleared", chan_status, 32'h0);
  endtask

  task automatic t_bt_dev;
    @(negedge clk);
    dev_status = 4'h5;
    @(negedge clk);
    check("R12 dev status", chan_status, 32'h0000_0005);
    seq_pulse(6'b000100);
    check("R12 bt set", chan_status, 32'h0000_0105);
    seq_pulse(6'b000010);
    check("R12 bt clear", chan_status, 32'h0000_0005);
    host_wr(3, 32'h0000_0044);
    check("R7 unlocked again", cmd_ptr, 32'h0000_0040);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ptr_idle();
    t_run();
    t_ptr_active();
    t_pause();
    t_wake();
    t_flush();
    t_readmap();
    t_sel();
    t_partial();
    t_stop_run();
    t_dead();
    t_bt_dev();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule